// File: doc/BRIEF.md
# Four-Lane Column Rate-Match FIFO

This block is an elastic buffer between a recovered receive clock and a local clock on a four-lane link. The link has already been decoded from 8b/10b. Each stored column is one byte plus a control flag for each lane. Data is written on the receive clock and read on the local clock. The two clocks run at nearly, but not exactly, the same rate.

The buffer makes up the rate difference by editing idle columns only. An idle column is one in which every lane carries the R control character: control flag 1 and byte value 0x7C. When the buffer runs high, an incoming idle column is dropped rather than stored. When it runs low, an idle column at the head is replayed rather than consumed. Each edit shows up as a one-cycle pulse on the read side. Per-lane empty and full flags report the low and high watermarks.

After reset, the read side sends idle columns and does not consume until the buffer has filled to its midpoint. This gives the rate adjustment room in both directions.

Top module: `rate_match_fifo`

## Requirements
- R1: A column in which any lane is not control-flag 1 with byte 0x7C leaves the read port unchanged, in write order, exactly once. This includes columns where only one lane differs.
- R2: An incoming column is dropped, not stored, exactly when three conditions hold: write-side occupancy is 20 or more, every lane is control 1 / 0x7C, and the previous incoming column was not dropped.
- R3: For each dropped column, `deleted_o` is high for exactly one read cycle. That cycle is the one in which the first column stored after the drop appears on the read port.
- R4: Once reading has started, an R column is output without advancing the read pointer, with `inserted_o` high in that cycle, whenever either of two conditions holds: read-side occupancy is 0, or read-side occupancy is 5 or less and the head column is an R column.
- R5: All bits of `empty_o` are high exactly while read-side occupancy is 5 or less.
- R6: All bits of `full_o` are high exactly while write-side occupancy is 20 or more. Occupancy never exceeds the depth of 32.
- R7: After reset, the read port carries R columns with both pulses low until read-side occupancy has reached 12. Consumption starts only after that.
- R8: While reset is asserted, the read port shows an R column with control 4'hF and data 32'h7C7C7C7C, both pulses are low, `empty_o` is 4'hF and `full_o` is 4'h0.
- R9: `inserted_o` and `deleted_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered (write) clock |
| rd_clk_i | input | 1 | Local (read) clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_data_i | input | 32 | Incoming column bytes, lane n in bits 8n+7:8n |
| wr_ctrl_i | input | 4 | Incoming control flags, one per lane |
| rd_data_o | output | 32 | Outgoing column bytes |
| rd_ctrl_o | output | 4 | Outgoing control flags |
| empty_o | output | 4 | Low-watermark flag per lane (read domain) |
| full_o | output | 4 | High-watermark flag per lane (write domain) |
| inserted_o | output | 1 | One-cycle pulse per replayed R column |
| deleted_o | output | 1 | One-cycle pulse per dropped R column |

## Verification
The deletion pulse arrives in the same read cycle as an ordinary column: the first column stored after the dropped one, which is often a non-idle data column. The same column may also be one that the read side wants to replay. The bench provokes this by switching the write clock between faster and slower than the read clock while feeding a mixed stream of idle, near-idle and data columns. It judges the result by checking the order of every non-idle column and by reconciling the pulse counts against drops it predicts from `full_o` at each write edge. It also checks that no cycle carries both pulses and that every replay follows a cycle with `empty_o` high.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int unsigned LANES = 4;
  localparam logic [7:0] IDLE_BYTE = 8'h7C;
  localparam logic [LANES*8-1:0] IDLE_DATA = {LANES{IDLE_BYTE}};

  function automatic logic col_is_idle(input logic [LANES*8-1:0] d, input logic [LANES-1:0] k);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (!k[i] || d[i*8 +: 8] != IDLE_BYTE) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/rmf_ptr_sync.sv
module rmf_ptr_sync #(
  parameter int unsigned PW = 6
) (
  input  logic          src_clk_i,
  input  logic          dst_clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ptr_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] gray_q, s1_q, s2_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_q <= '0;
    else         gray_q <= ptr_i ^ (ptr_i >> 1);
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_q;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) ptr_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/rmf_mem.sv
module rmf_mem #(
  parameter int unsigned EW    = 37,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [EW-1:0] rdata_o
);
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rmf_wr_ctl.sv
module rmf_wr_ctl import rmf_pkg::*; #(
  parameter int unsigned HI_MARK = 20,
  parameter int unsigned PW      = 6,
  parameter int unsigned EW      = 37
) (
  input  logic                 wr_clk_i,
  input  logic                 rst_ni,
  input  logic [LANES*8-1:0]   data_i,
  input  logic [LANES-1:0]     ctrl_i,
  input  logic [PW-1:0]        rptr_i,
  output logic [PW-1:0]        wptr_o,
  output logic                 we_o,
  output logic [EW-1:0]        entry_o,
  output logic                 full_o,
  output logic                 drop_o,
  output logic [PW-1:0]        fill_o
);
  logic [PW-1:0] wptr_q;
  logic          drop_q;

  assign fill_o  = wptr_q - rptr_i;
  assign full_o  = fill_o >= PW'(HI_MARK);
  // at most one drop between stored columns, so one mark bit covers it
  assign drop_o  = full_o && col_is_idle(data_i, ctrl_i) && !drop_q;
  assign we_o    = !drop_o;
  assign entry_o = {drop_q, ctrl_i, data_i};
  assign wptr_o  = wptr_q;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      drop_q <= 1'b0;
    end else begin
      drop_q <= drop_o;
      if (!drop_o) wptr_q <= wptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rmf_rd_ctl.sv
module rmf_rd_ctl import rmf_pkg::*; #(
  parameter int unsigned LO_MARK    = 5,
  parameter int unsigned START_MARK = 12,
  parameter int unsigned PW         = 6,
  parameter int unsigned EW         = 37
) (
  input  logic               rd_clk_i,
  input  logic               rst_ni,
  input  logic [PW-1:0]      wptr_i,
  input  logic [EW-1:0]      head_i,
  output logic [PW-1:0]      rptr_o,
  output logic [LANES*8-1:0] data_o,
  output logic [LANES-1:0]   ctrl_o,
  output logic               inserted_o,
  output logic               deleted_o,
  output logic               empty_o,
  output logic               started_o
);
  logic [PW-1:0] rptr_q, fill;
  logic          started_q, head_idle, head_mark, ins, pop;

  assign fill      = wptr_i - rptr_q;
  assign empty_o   = fill <= PW'(LO_MARK);
  assign head_idle = col_is_idle(head_i[LANES*8-1:0], head_i[LANES*9-1:LANES*8]);
  assign head_mark = head_i[EW-1];
  assign ins       = started_q && (fill == '0 || (empty_o && head_idle));
  assign pop       = started_q && !ins;
  assign rptr_o    = rptr_q;
  assign started_o = started_q;

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q     <= '0;
      started_q  <= 1'b0;
      data_o     <= IDLE_DATA;
      ctrl_o     <= '1;
      inserted_o <= 1'b0;
      deleted_o  <= 1'b0;
    end else begin
      if (!started_q && fill >= PW'(START_MARK)) started_q <= 1'b1;
      if (pop) rptr_q <= rptr_q + 1'b1;
      data_o     <= pop ? head_i[LANES*8-1:0] : IDLE_DATA;
      ctrl_o     <= pop ? head_i[LANES*9-1:LANES*8] : '1;
      inserted_o <= ins;
      deleted_o  <= pop && head_mark;
    end
  end
endmodule

// File: rtl/rate_match_fifo.sv
module rate_match_fifo import rmf_pkg::*; #(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned LO_MARK    = 5,
  parameter int unsigned HI_MARK    = 20,
  parameter int unsigned START_MARK = 12
) (
  input  logic               wr_clk_i,
  input  logic               rd_clk_i,
  input  logic               rst_ni,
  input  logic [LANES*8-1:0] wr_data_i,
  input  logic [LANES-1:0]   wr_ctrl_i,
  output logic [LANES*8-1:0] rd_data_o,
  output logic [LANES-1:0]   rd_ctrl_o,
  output logic [LANES-1:0]   empty_o,
  output logic [LANES-1:0]   full_o,
  output logic               inserted_o,
  output logic               deleted_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam int unsigned EW = 1 + LANES * 9;

  logic [PW-1:0] wptr, rptr, wptr_sync, rptr_sync, wr_fill;
  logic [EW-1:0] wentry, head;
  logic          we, wr_drop, wr_full, rd_empty, rd_started;

  rmf_wr_ctl #(.HI_MARK(HI_MARK), .PW(PW), .EW(EW)) u_wr (
    .wr_clk_i(wr_clk_i), .rst_ni(rst_ni), .data_i(wr_data_i), .ctrl_i(wr_ctrl_i),
    .rptr_i(rptr_sync), .wptr_o(wptr), .we_o(we), .entry_o(wentry),
    .full_o(wr_full), .drop_o(wr_drop), .fill_o(wr_fill)
  );

  rmf_mem #(.EW(EW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wr_clk_i(wr_clk_i), .we_i(we), .waddr_i(wptr[AW-1:0]), .wdata_i(wentry),
    .raddr_i(rptr[AW-1:0]), .rdata_o(head)
  );

  rmf_ptr_sync #(.PW(PW)) u_w2r (
    .src_clk_i(wr_clk_i), .dst_clk_i(rd_clk_i), .rst_ni(rst_ni),
    .ptr_i(wptr), .ptr_o(wptr_sync)
  );

  rmf_ptr_sync #(.PW(PW)) u_r2w (
    .src_clk_i(rd_clk_i), .dst_clk_i(wr_clk_i), .rst_ni(rst_ni),
    .ptr_i(rptr), .ptr_o(rptr_sync)
  );

  rmf_rd_ctl #(.LO_MARK(LO_MARK), .START_MARK(START_MARK), .PW(PW), .EW(EW)) u_rd (
    .rd_clk_i(rd_clk_i), .rst_ni(rst_ni), .wptr_i(wptr_sync), .head_i(head),
    .rptr_o(rptr), .data_o(rd_data_o), .ctrl_o(rd_ctrl_o),
    .inserted_o(inserted_o), .deleted_o(deleted_o),
    .empty_o(rd_empty), .started_o(rd_started)
  );

  assign empty_o = {LANES{rd_empty}};
  assign full_o  = {LANES{wr_full}};
endmodule

// File: rtl/rate_match_fifo_chk.sv
module rate_match_fifo_chk import rmf_pkg::*; #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PW    = 6
) (
  input logic               wr_clk_i,
  input logic               rd_clk_i,
  input logic               rst_ni,
  input logic [LANES*8-1:0] wr_data_i,
  input logic [LANES-1:0]   wr_ctrl_i,
  input logic               wr_drop_i,
  input logic [PW-1:0]      wr_fill_i,
  input logic [LANES*8-1:0] rd_data_i,
  input logic [LANES-1:0]   rd_ctrl_i,
  input logic [LANES-1:0]   empty_i,
  input logic [LANES-1:0]   full_i,
  input logic               inserted_i,
  input logic               deleted_i,
  input logic               started_i
);
  logic in_idle;
  assign in_idle = (wr_ctrl_i == '1) && (wr_data_i == {LANES{8'h7C}});

  assert_drop_needs_idle_full_R2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_drop_i |-> (in_idle && full_i[0]));

  assert_drop_spaced_R2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_drop_i |=> !wr_drop_i);

  assert_no_overflow_R6: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_fill_i <= PW'(DEPTH));

  assert_insert_is_idle_R4: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    inserted_i |-> (rd_ctrl_i == '1 && rd_data_i == {LANES{8'h7C}}));

  assert_insert_after_low_R5: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    inserted_i |-> $past(empty_i[0]));

  assert_quiet_startup_R7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !$past(started_i) |-> (!inserted_i && !deleted_i));

  assert_no_edit_overlap_R9: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !(inserted_i && deleted_i));
endmodule

bind rate_match_fifo rate_match_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .wr_data_i(wr_data_i), .wr_ctrl_i(wr_ctrl_i),
  .wr_drop_i(wr_drop), .wr_fill_i(wr_fill),
  .rd_data_i(rd_data_o), .rd_ctrl_i(rd_ctrl_o),
  .empty_i(empty_o), .full_i(full_o),
  .inserted_i(inserted_o), .deleted_i(deleted_o), .started_i(rd_started)
);

// File: tb/tb_rate_match_fifo.sv
`timescale 1ns/1ps
module tb_rate_match_fifo;
  import rmf_pkg::*;
  localparam int START = 12;

  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] wr_data;
  logic [3:0]  wr_ctrl;
  logic [31:0] rd_data;
  logic [3:0]  rd_ctrl, empty_o, full_o;
  logic        inserted_o, deleted_o;
  real         wr_half = 4.5;

  rate_match_fifo dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_data_i(wr_data), .wr_ctrl_i(wr_ctrl),
    .rd_data_o(rd_data), .rd_ctrl_o(rd_ctrl),
    .empty_o(empty_o), .full_o(full_o),
    .inserted_o(inserted_o), .deleted_o(deleted_o)
  );

  always #5 rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  int checks = 0, fails = 0;
  int n_wr = 0, r_written = 0, exp_drops = 0, ins_cnt = 0, del_cnt = 0, r_pop = 0, seq = 0;
  bit mon_on = 0, done = 0, final_pushed = 0, seen_first = 0;
  bit seen_full = 0, seen_empty = 0, prev_empty = 1, prev_drop = 0;
  logic [35:0] q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_r(input logic [31:0] d, input logic [3:0] k);
    return (k == 4'hF) && (d == 32'h7C7C7C7C);
  endfunction

  task automatic gen(output logic [31:0] d, output logic [3:0] k);
    int kind;
    kind = $urandom_range(0, 99);
    if (kind < 55) begin
      d = 32'h7C7C7C7C; k = 4'hF;
    end else if (kind < 62) begin
      d = 32'h7C7C7C7C; k = 4'hF;
      d[$urandom_range(0, 3)*8 +: 8] = 8'hFC;
    end else if (kind < 69) begin
      d = 32'h7C7C7C7C; k = 4'hF;
      k[$urandom_range(0, 3)] = 1'b0;
    end else begin
      d = $urandom; k = 4'($urandom);
      d[7:0] = seq[7:0]; k[0] = 1'b0;
      seq++;
    end
  endtask

  task automatic write_col(input logic [31:0] d, input logic [3:0] k, input bit tail);
    bit r, drop;
    @(negedge wr_clk);
    r = is_r(d, k);
    chk(full_o == 4'h0 || full_o == 4'hF, "R6", "full lanes uniform", 64'(full_o), 64'hF);
    if (full_o[0]) seen_full = 1;
    drop = full_o[0] && r && !prev_drop;
    prev_drop = drop;
    if (!tail) begin
      if (r) begin
        r_written++;
        if (drop) exp_drops++;
      end else q.push_back({k, d});
    end
    wr_data = d; wr_ctrl = k; n_wr++;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge rd_clk);
      if (mon_on && !done) begin
        bit col_r;
        col_r = is_r(rd_data, rd_ctrl);
        if (!seen_first) begin
          if (col_r)
            chk(!inserted_o && !deleted_o, "R7", "pulse during startup",
                64'({inserted_o, deleted_o}), 64'h0);
          else begin
            seen_first = 1;
            chk(n_wr >= START, "R7", "read began before midpoint", 64'(n_wr), 64'(START));
          end
        end
        if (seen_first) begin
          chk(empty_o == 4'h0 || empty_o == 4'hF, "R5", "empty lanes uniform", 64'(empty_o), 64'hF);
          if (empty_o[0]) seen_empty = 1;
          if (inserted_o) begin
            ins_cnt++;
            chk(col_r, "R4", "inserted column not R", 64'({rd_ctrl, rd_data}), 64'hF7C7C7C7C);
            chk(prev_empty, "R5", "insert without low watermark", 64'(prev_empty), 64'h1);
            chk(!deleted_o, "R9", "insert and delete together", 64'(deleted_o), 64'h0);
          end else begin
            if (deleted_o) del_cnt++;
            if (col_r) r_pop++;
            else begin
              logic [35:0] exp;
              if (q.size() == 0) begin
                chk(0, "R1", "unexpected data column", 64'({rd_ctrl, rd_data}), 64'h0);
              end else begin
                exp = q.pop_front();
                chk({rd_ctrl, rd_data} == exp, "R1", "data column mismatch",
                    64'({rd_ctrl, rd_data}), 64'(exp));
                if (q.size() == 0 && final_pushed) begin
                  chk(del_cnt == exp_drops, "R3", "deleted pulse count", 64'(del_cnt), 64'(exp_drops));
                  chk(r_pop + del_cnt == r_written, "R2", "R column accounting",
                      64'(r_pop + del_cnt), 64'(r_written));
                  chk(del_cnt > 0, "R2", "no deletion provoked", 64'(del_cnt), 64'h1);
                  chk(ins_cnt > 0, "R4", "no insertion provoked", 64'(ins_cnt), 64'h1);
                  chk(seen_full, "R6", "full never seen", 64'(seen_full), 64'h1);
                  chk(seen_empty, "R5", "empty never seen", 64'(seen_empty), 64'h1);
                  done = 1;
                end
              end
            end
          end
        end
        prev_empty = empty_o[0];
      end
    end
  end

  // driver
  initial begin
    logic [31:0] d;
    logic [3:0]  k;
    real halves[4] = '{4.5, 5.5, 4.5, 5.5};
    d = $urandom; k = 4'hE; d[7:0] = 8'hA5;
    wr_data = d; wr_ctrl = k; q.push_back({k, d}); n_wr = 1;
    repeat (3) @(negedge rd_clk);
    // R8 reset state
    chk(rd_ctrl == 4'hF && rd_data == 32'h7C7C7C7C, "R8", "reset column",
        64'({rd_ctrl, rd_data}), 64'hF7C7C7C7C);
    chk(!inserted_o && !deleted_o, "R8", "reset pulses", 64'({inserted_o, deleted_o}), 64'h0);
    chk(empty_o == 4'hF, "R8", "reset empty", 64'(empty_o), 64'hF);
    chk(full_o == 4'h0, "R8", "reset full", 64'(full_o), 64'h0);
    @(negedge wr_clk);
    rst_ni = 1'b1;
    mon_on = 1;
    for (int p = 0; p < 4; p++) begin
      wr_half = halves[p];
      for (int i = 0; i < 1200; i++) begin
        gen(d, k);
        write_col(d, k, 1'b0);
      end
    end
    d = 32'h11223344; k = 4'h0; d[7:0] = 8'hEE;
    write_col(d, k, 1'b0);
    final_pushed = 1;
    while (!done) write_col(32'h7C7C7C7C, 4'hF, 1'b1);
    #20;
    finish_run();
  end

  // watchdog
  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule